// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a small processor and decides where the program counter goes next, so that loops cost no branch instructions and no bubbles. It supports two looping commands. A repeat command makes the single instruction after it issue again and again. A block-loop command runs a stretch of instructions, from the one after the command up to a programmed last address, again and again. Each command carries an iteration count. Dedicated counter registers inside the block hold the count, not the general registers.

Each cycle the decoder gives the block the address of the instruction being issued, an issue strobe and any loop-setup command decoded from that instruction. The block returns the address to fetch next and the kind of step it chose. It also drives one busy flag for each loop type. A repeat may run inside a block-loop body. The repeat always finishes before the block-loop checks for its last address.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset both busy flags are low. An issued instruction with no loop pending gives `next_pc = pc + 1` and `pc_sel = 0` (sequential).
- R2: A repeat command with count N, issued at address A, makes the instruction at A+1 issue N+1 times. For its first N issues the block returns `next_pc = A+1` with `pc_sel = 1` (hold). On the last issue it returns `A+2` with `pc_sel = 0`.
- R3: A repeat count of zero makes the next instruction issue exactly once, and no hold step is produced.
- R4: A block-loop command at address S with count N and last address E makes the body S+1..E run N+1 times. Each time E issues with iterations left, the block returns `next_pc = S+1` with `pc_sel = 2` (loop) in that same cycle, so no cycle is added. After the final pass it falls through to E+1.
- R5: A block-loop whose body is one instruction (E = S+1) loops on that instruction with `pc_sel = 2` and then falls through.
- R6: Each busy flag rises in the cycle after its setup command issues. It stays high through the final issued iteration and is low in the cycle after that.
- R7: A setup command of a loop type that is already busy is ignored: it leaves that loop's count, start and last address as they were.
- R8: When the last body address of an active block-loop is being repeated, the hold steps come first. The loop-back or fall-through decision is taken only on the repeat's final issue.
- R9: While the issue strobe is low, the block returns `next_pc = pc` with `pc_sel = 1` and changes no loop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc | input | PC_W | Address of the instruction in the issue slot |
| issue | input | 1 | The instruction at `pc` issues this cycle |
| rep_setup | input | 1 | Issued instruction is a repeat command |
| rep_count | input | CNT_W | Repeat count N (body runs N+1 times) |
| blk_setup | input | 1 | Issued instruction is a block-loop command |
| blk_count | input | CNT_W | Block-loop count N (body runs N+1 times) |
| blk_last | input | PC_W | Last address of the block-loop body |
| next_pc | output | PC_W | Address to fetch next |
| pc_sel | output | 2 | Step kind: 0 sequential, 1 hold, 2 loop-back |
| rep_busy | output | 1 | A repeat is in progress |
| blk_busy | output | 1 | A block-loop is in progress |

## Verification
The bench goes after the count boundaries. With a zero repeat count, a design that held once would show a spurious hold step. With count N, a design off by one would give one hold too many or too few. On the block-loop side it checks a one-instruction body and a repeated instruction at the body's last address. A design that tested the last address before the repeat drained would jump back early and cut the repeat short. It also sends setup commands while a loop is busy and stalls in the middle of a repeat. A design that reloaded its registers, or counted down during a stall, would end the loop at the wrong cycle.

// File: rtl/hwloop_pkg.sv
// Shared types for the hardware loop controller.
package hwloop_pkg;
    // Kind of program-counter step chosen for the next fetch.
    typedef enum logic [1:0] {
        PC_SEQ  = 2'd0,
        PC_HOLD = 2'd1,
        PC_LOOP = 2'd2
    } pc_sel_e;
endpackage

// File: rtl/hwloop_rep_unit.sv
// Single-instruction repeat engine.
// Loads a count when a repeat command issues while idle, then requests the
// PC be held while iterations remain. Assumes the repeated instruction is the
// one issued right after the command. Nothing moves while issue is low.
module hwloop_rep_unit #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             setup,
    input  logic [CNT_W-1:0] count_in,
    output logic             active,
    output logic             hold
);
    logic [CNT_W-1:0] cnt;

    // Count register and busy flag: load on setup, count down, clear on last pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (issue) begin
            if (!active && setup) begin
                active <= 1'b1;
                cnt    <= count_in;
            end else if (active) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                else           active <= 1'b0;
            end
        end
    end

    // Hold request: iterations remain beyond the current one.
    always_comb hold = active && (cnt != '0);

    AST_REP_HOLD_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && hold) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_REP_SETUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && hold && setup) |=> (active && cnt == $past(cnt) - 1'b1)); // R7
    AST_REP_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(cnt) && $stable(active))); // R9
endmodule

// File: rtl/hwloop_blk_unit.sv
// Multi-instruction block-loop engine.
// Stores the start (address after the command), last address and count.
// When the last address issues, with no repeat draining and passes left, it
// requests a loop-back and counts down in that cycle. Assumes the body has
// at least one instruction.
module hwloop_blk_unit #(
    parameter int PC_W  = 16,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc,
    input  logic             issue,
    input  logic             setup,
    input  logic [CNT_W-1:0] count_in,
    input  logic [PC_W-1:0]  last_in,
    input  logic             rep_hold,
    output logic             active,
    output logic             jump,
    output logic [PC_W-1:0]  start_pc
);
    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0]  last_r;
    logic             at_end;

    // End-of-body detection, deferred while a repeat still holds the PC.
    always_comb begin
        at_end = active && issue && !rep_hold && (pc == last_r);
        jump   = at_end && (cnt != '0);
    end

    // Loop registers: load on setup when idle, count down on loop-back, clear at exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            last_r   <= '0;
            start_pc <= '0;
        end else if (issue && setup && !active) begin
            active   <= 1'b1;
            cnt      <= count_in;
            last_r   <= last_in;
            start_pc <= pc + 1'b1;
        end else if (jump) begin
            cnt <= cnt - 1'b1;
        end else if (at_end) begin
            active <= 1'b0;
        end
    end

    AST_BLK_LOOP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (cnt == $past(cnt) - 1'b1)); // R4
    AST_BLK_REPEAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rep_hold |-> !jump); // R8
    AST_BLK_SETUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && setup) |=> ($stable(start_pc) && $stable(last_r))); // R7
endmodule

// File: rtl/hwloop_pc_mux.sv
// Next-PC selector. Priority: stall, repeat hold, block loop-back, sequential.
// Assumes each request input is already qualified by its engine.
module hwloop_pc_mux
    import hwloop_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc,
    input  logic            issue,
    input  logic            rep_hold,
    input  logic            blk_jump,
    input  logic [PC_W-1:0] loop_start,
    output logic [PC_W-1:0] next_pc,
    output pc_sel_e         sel
);
    // Priority select of the next fetch address.
    always_comb begin
        if (!issue || rep_hold) begin
            sel     = PC_HOLD;
            next_pc = pc;
        end else if (blk_jump) begin
            sel     = PC_LOOP;
            next_pc = loop_start;
        end else begin
            sel     = PC_SEQ;
            next_pc = pc + 1'b1;
        end
    end

    AST_MUX_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PC_SEQ) |-> (issue && next_pc == pc + 1'b1)); // R1
    AST_MUX_HOLD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && rep_hold) |-> (sel == PC_HOLD)); // R8
endmodule

// File: rtl/hwloop_ctrl.sv
// Zero-overhead hardware loop controller (top).
// Joins the repeat engine, the block-loop engine and the next-PC selector.
// One level of each loop type. The repeat engine's hold request gates the
// block engine's end-of-body check, so a repeat drains first.
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc,
    input  logic             issue,
    input  logic             rep_setup,
    input  logic [CNT_W-1:0] rep_count,
    input  logic             blk_setup,
    input  logic [CNT_W-1:0] blk_count,
    input  logic [PC_W-1:0]  blk_last,
    output logic [PC_W-1:0]  next_pc,
    output logic [1:0]       pc_sel,
    output logic             rep_busy,
    output logic             blk_busy
);
    logic            rep_hold;
    logic            blk_jump;
    logic [PC_W-1:0] loop_start;
    pc_sel_e         sel;

    hwloop_rep_unit #(.CNT_W(CNT_W)) u_rep (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .setup    (rep_setup),
        .count_in (rep_count),
        .active   (rep_busy),
        .hold     (rep_hold)
    );

    hwloop_blk_unit #(.PC_W(PC_W), .CNT_W(CNT_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc       (pc),
        .issue    (issue),
        .setup    (blk_setup),
        .count_in (blk_count),
        .last_in  (blk_last),
        .rep_hold (rep_hold),
        .active   (blk_busy),
        .jump     (blk_jump),
        .start_pc (loop_start)
    );

    hwloop_pc_mux #(.PC_W(PC_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc         (pc),
        .issue      (issue),
        .rep_hold   (rep_hold),
        .blk_jump   (blk_jump),
        .loop_start (loop_start),
        .next_pc    (next_pc),
        .sel        (sel)
    );

    // Expose the step kind as a plain vector.
    always_comb pc_sel = sel;

    AST_TOP_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |-> (next_pc == pc && pc_sel == 2'd1)); // R9
    AST_TOP_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_busy) |-> $past(rep_setup && issue)); // R6
endmodule

// File: tb/tb_hwloop_ctrl.sv
// Scoreboard bench: the driver queues the expected result for each cycle and
// the monitor pops and compares it shortly after the inputs settle.
module tb_hwloop_ctrl;
    localparam int PC_W  = 16;
    localparam int CNT_W = 14;
    localparam int WATCHDOG_CYC = 5000;

    typedef struct {
        logic [PC_W-1:0] nxt;
        logic [1:0]      sel;
        logic            rb;
        logic            bb;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pc = '0;
    logic             issue = 1'b0;
    logic             rep_setup = 1'b0;
    logic [CNT_W-1:0] rep_count = '0;
    logic             blk_setup = 1'b0;
    logic [CNT_W-1:0] blk_count = '0;
    logic [PC_W-1:0]  blk_last = '0;
    logic [PC_W-1:0]  next_pc;
    logic [1:0]       pc_sel;
    logic             rep_busy;
    logic             blk_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    hwloop_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .pc(pc), .issue(issue),
        .rep_setup(rep_setup), .rep_count(rep_count),
        .blk_setup(blk_setup), .blk_count(blk_count), .blk_last(blk_last),
        .next_pc(next_pc), .pc_sel(pc_sel), .rep_busy(rep_busy), .blk_busy(blk_busy)
    );

    localparam logic [1:0] SEQ = 2'd0, HLD = 2'd1, LP = 2'd2;

    // Driver: apply one cycle of inputs and queue its expected outputs.
    task automatic step(input logic [PC_W-1:0] a, input logic iss,
                        input logic rs, input logic [CNT_W-1:0] rc,
                        input logic bs, input logic [CNT_W-1:0] bc,
                        input logic [PC_W-1:0] bl,
                        input logic [PC_W-1:0] e_nxt, input logic [1:0] e_sel,
                        input logic e_rb, input logic e_bb, input string tag);
        exp_t e;
        @(negedge clk);
        pc = a; issue = iss; rep_setup = rs; rep_count = rc;
        blk_setup = bs; blk_count = bc; blk_last = bl;
        e.nxt = e_nxt; e.sel = e_sel; e.rb = e_rb; e.bb = e_bb; e.tag = tag;
        sb.push_back(e);
    endtask

    // Plain issued instruction with no setup command.
    task automatic run(input logic [PC_W-1:0] a, input logic [PC_W-1:0] e_nxt,
                       input logic [1:0] e_sel, input logic e_rb, input logic e_bb,
                       input string tag);
        step(a, 1'b1, 1'b0, '0, 1'b0, '0, '0, e_nxt, e_sel, e_rb, e_bb, tag);
    endtask

    // Monitor: compare outputs against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (next_pc !== e.nxt || pc_sel !== e.sel ||
                    rep_busy !== e.rb || blk_busy !== e.bb) begin
                    fails++;
                    $display("FAIL %s: got next_pc=%0d sel=%0d rep=%0b blk=%0b, expected next_pc=%0d sel=%0d rep=%0b blk=%0b",
                             e.tag, next_pc, pc_sel, rep_busy, blk_busy,
                             e.nxt, e.sel, e.rb, e.bb);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sequential step.
        run(16'd100, 16'd101, SEQ, 0, 0, "R1 reset");

        // R2/R6/R7/R9: repeat count 3 with a stall and an ignored setup.
        step(16'd10, 1, 1, 14'd3, 0, '0, '0, 16'd11, SEQ, 0, 0, "R2 repeat cmd");
        run(16'd11, 16'd11, HLD, 1, 0, "R2 hold 1 / R6 busy");
        step(16'd11, 1, 1, 14'd9, 0, '0, '0, 16'd11, HLD, 1, 0, "R7 repeat setup ignored");
        step(16'd11, 0, 0, '0, 0, '0, '0, 16'd11, HLD, 1, 0, "R9 stall");
        run(16'd11, 16'd11, HLD, 1, 0, "R2 hold 3");
        run(16'd11, 16'd12, SEQ, 1, 0, "R2 final issue");
        run(16'd12, 16'd13, SEQ, 0, 0, "R6 repeat busy clears");

        // R3: zero repeat count.
        step(16'd20, 1, 1, 14'd0, 0, '0, '0, 16'd21, SEQ, 0, 0, "R3 repeat cmd");
        run(16'd21, 16'd22, SEQ, 1, 0, "R3 single issue");
        run(16'd22, 16'd23, SEQ, 0, 0, "R3 busy clears");

        // R4/R6/R7: block loop count 2 over 31..32.
        step(16'd30, 1, 0, '0, 1, 14'd2, 16'd32, 16'd31, SEQ, 0, 0, "R4 block cmd");
        run(16'd31, 16'd32, SEQ, 0, 1, "R4 pass1 / R6 busy");
        run(16'd32, 16'd31, LP, 0, 1, "R4 loop-back 1");
        step(16'd31, 1, 0, '0, 1, 14'd0, 16'd31, 16'd32, SEQ, 0, 1, "R7 block setup ignored");
        run(16'd32, 16'd31, LP, 0, 1, "R4 loop-back 2");
        run(16'd31, 16'd32, SEQ, 0, 1, "R4 pass3");
        run(16'd32, 16'd33, SEQ, 0, 1, "R4 fall through");
        run(16'd33, 16'd34, SEQ, 0, 0, "R6 block busy clears");

        // R5: one-instruction body, count 1.
        step(16'd40, 1, 0, '0, 1, 14'd1, 16'd41, 16'd41, SEQ, 0, 0, "R5 block cmd");
        run(16'd41, 16'd41, LP, 0, 1, "R5 loop on self");
        run(16'd41, 16'd42, SEQ, 0, 1, "R5 fall through");
        run(16'd42, 16'd43, SEQ, 0, 0, "R5 busy clears");

        // R8: repeat of the last body instruction inside a block loop.
        step(16'd50, 1, 0, '0, 1, 14'd1, 16'd52, 16'd51, SEQ, 0, 0, "R8 block cmd");
        step(16'd51, 1, 1, 14'd2, 0, '0, '0, 16'd52, SEQ, 0, 1, "R8 repeat cmd 1");
        run(16'd52, 16'd52, HLD, 1, 1, "R8 hold at end 1");
        run(16'd52, 16'd52, HLD, 1, 1, "R8 hold at end 2");
        run(16'd52, 16'd51, LP, 1, 1, "R8 loop after repeat");
        step(16'd51, 1, 1, 14'd2, 0, '0, '0, 16'd52, SEQ, 0, 1, "R8 repeat cmd 2");
        run(16'd52, 16'd52, HLD, 1, 1, "R8 hold at end 3");
        run(16'd52, 16'd52, HLD, 1, 1, "R8 hold at end 4");
        run(16'd52, 16'd53, SEQ, 1, 1, "R8 exit after repeat");
        run(16'd53, 16'd54, SEQ, 0, 0, "R8 both clear");

        step(16'd0, 0, 0, '0, 0, '0, '0, 16'd0, HLD, 0, 0, "R9 idle stall");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule